// File: doc/BRIEF.md
# Half-Duplex Frame Transmit Sequencer

This block decides when a 10/100 Ethernet MAC may put a frame on a 4-bit transmit path, and how that frame ends. The frame source holds a request and a length in nibbles. The sequencer then waits out the minimum interframe gap. In half-duplex operation it also waits for the line to go quiet. It then drives the transmit enable for one nibble per clock-enable tick. While the frame is on the line, it watches carrier sense and collision. After a collision it retries the frame following a random slot-time backoff, or gives up on it.

Every frame, whatever its outcome, ends with a one-cycle done pulse. Any status flag for that frame (no carrier, carrier lost, too many collisions) appears in the same cycle as the pulse. In half-duplex mode a gating output tells the receiver to discard what it hears while the MAC is transmitting. Full-duplex mode turns off deferral, collision handling and carrier checking entirely.

Top module: `hdx_tx_sequencer`

## Requirements
- R1: The minimum gap, counted in ticks with transmit enable low between one attempt and the next, is 24 − 2×`cfg_gap`. Code 0 gives 24 ticks (96 bit times) and code 7 gives 10 ticks (40 bit times). In half-duplex mode any value below 16 ticks is raised to 16.
- R2: In half-duplex mode a new attempt never starts while `crs` is high. In full-duplex mode `crs` does not delay a start.
- R3: In a half-duplex attempt where carrier checking is enabled and `crs` is never high, the frame runs to its full length and ends with `st_no_carrier`.
- R4: In a half-duplex attempt where carrier checking is enabled and `crs` falls after it was seen high, the frame is cut short and ends with `st_loss_carrier`.
- R5: With `cfg_crs_ignore` set, `crs` has no effect on a half-duplex frame in progress: it runs to full length and reports no carrier status.
- R6: A half-duplex collision drops transmit enable and the frame is retried after a backoff. A frame that collides k times (k < 16) is sent k+1 times and ends with no status.
- R7: With `cfg_no_retry` set, the first half-duplex collision ends the frame with `st_excess_col` after one attempt.
- R8: A frame that collides on every attempt is sent exactly 16 times and then ends with `st_excess_col`.
- R9: In full-duplex mode `col` and `crs` have no effect: the frame is sent once, at full length, with no status.
- R10: `rx_block` is high only while transmit enable is high, the link is half-duplex and `cfg_rx_own_block` is set.
- R11: With `speed_fast` low, one tick occurs every 10 clocks, so a frame of N nibbles holds `tx_en` for 10×N clocks. With `speed_fast` high, a tick occurs on every clock.
- R12: `frame_done` is a single-cycle pulse that rises in the cycle `tx_en` falls at the end of a frame. The status outputs pulse only together with it, and at most one status output is set per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst | input | 1 | Synchronous active-high reset |
| speed_fast | input | 1 | 1 = 100 Mbit/s (tick every clock), 0 = 10 Mbit/s (tick every 10 clocks) |
| cfg_gap | input | 3 | Interframe gap code, 0 = longest |
| cfg_full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| cfg_crs_ignore | input | 1 | Disables carrier error checking during transmission |
| cfg_no_retry | input | 1 | Abort the frame on its first collision |
| cfg_rx_own_block | input | 1 | Gate reception while transmitting in half duplex |
| frame_req | input | 1 | Frame pending, held until `frame_done` |
| frame_len | input | LEN_W | Frame length in nibbles (at least 1) |
| crs | input | 1 | Carrier sense from the line |
| col | input | 1 | Collision detect from the line |
| tx_en | output | 1 | Transmit enable |
| rx_block | output | 1 | Tells the receiver to drop incoming data |
| frame_done | output | 1 | One-cycle pulse when a frame ends |
| st_no_carrier | output | 1 | Frame ended without carrier ever being seen |
| st_loss_carrier | output | 1 | Frame aborted because carrier dropped |
| st_excess_col | output | 1 | Frame aborted after too many collisions |

## Verification
The hardest case to reach is the sixteenth consecutive collision. It needs a frame that collides on every attempt and comes through fifteen random backoffs. The line model in the bench raises `col` for as long as `tx_en` is high, with a collision budget it decrements each time `tx_en` falls, so each attempt meets a collision without the bench knowing the backoff lengths. The slot time is shortened through a parameter so that the longest backoffs still fit in the run. The carrier-lost abort is reached in a similar way: the line model echoes `tx_en` on `crs` for a set number of cycles and then releases it in the middle of the frame.

// File: rtl/hdx_tx_pkg.sv
package hdx_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_XMIT    = 2'd1,
        ST_BACKOFF = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic no_carrier;
        logic loss_carrier;
        logic excess_col;
    } frame_status_t;

    localparam int GAP_W = 5;

    // Gap in 4-bit ticks: 24 minus two per code step, floor of 16 when half duplex
    function automatic logic [GAP_W-1:0] gap_ticks(input logic [2:0] code,
                                                   input logic full_dup);
        logic [GAP_W-1:0] g;
        g = GAP_W'(24) - {1'b0, code, 1'b0};
        if (!full_dup && g < GAP_W'(16))
            g = GAP_W'(16);
        return g;
    endfunction

endpackage

// File: rtl/hdx_tick_gen.sv
module hdx_tick_gen #(
    parameter int SLOW_DIV = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic speed_fast,
    output logic tick
);
    localparam int CW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;

    logic [CW-1:0] div_cnt;

    always_ff @(posedge clk) begin
        if (rst || speed_fast || div_cnt == CW'(SLOW_DIV - 1))
            div_cnt <= '0;
        else
            div_cnt <= div_cnt + 1'b1;
    end

    assign tick = speed_fast || (div_cnt == '0);
endmodule

// File: rtl/hdx_gap_timer.sv
module hdx_gap_timer
    import hdx_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       load,
    input  logic [2:0] code,
    input  logic       full_dup,
    output logic       elapsed
);
    logic [GAP_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (load)
            remain <= gap_ticks(code, full_dup) - 1'b1;
        else if (tick && remain != '0)
            remain <= remain - 1'b1;
    end

    assign elapsed = (remain == '0);
endmodule

// File: rtl/hdx_backoff.sv
module hdx_backoff #(
    parameter int            ATT_W      = 5,
    parameter int            CAP        = 10,
    parameter int            SLOT_TICKS = 128,
    parameter logic [15:0]   SEED       = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic [ATT_W-1:0] attempt,
    output logic             expired
);
    localparam int BO_W = CAP + $clog2(SLOT_TICKS) + 1;

    logic [15:0]      lfsr;
    logic [BO_W-1:0]  wait_cnt;
    logic [ATT_W-1:0] expo;
    logic [CAP-1:0]   range_mask;
    logic [CAP-1:0]   slots;

    always_ff @(posedge clk) begin
        if (rst)
            lfsr <= SEED;
        else
            lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end

    always_comb begin
        expo       = (attempt > ATT_W'(CAP)) ? ATT_W'(CAP) : attempt;
        range_mask = ~({CAP{1'b1}} << expo);
        slots      = lfsr[CAP-1:0] & range_mask;
    end

    always_ff @(posedge clk) begin
        if (rst)
            wait_cnt <= '0;
        else if (load)
            wait_cnt <= BO_W'(slots) * BO_W'(SLOT_TICKS);
        else if (tick && wait_cnt != '0)
            wait_cnt <= wait_cnt - 1'b1;
    end

    assign expired = (wait_cnt == '0);
endmodule

// File: rtl/hdx_tx_sequencer.sv
module hdx_tx_sequencer
    import hdx_tx_pkg::*;
#(
    parameter int          LEN_W         = 12,
    parameter int          SLOW_DIV      = 10,
    parameter int          SLOT_TICKS    = 128,
    parameter int          ATTEMPT_LIMIT = 16,
    parameter int          BACKOFF_CAP   = 10,
    parameter logic [15:0] LFSR_SEED     = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             speed_fast,
    input  logic [2:0]       cfg_gap,
    input  logic             cfg_full_duplex,
    input  logic             cfg_crs_ignore,
    input  logic             cfg_no_retry,
    input  logic             cfg_rx_own_block,
    input  logic             frame_req,
    input  logic [LEN_W-1:0] frame_len,
    input  logic             crs,
    input  logic             col,
    output logic             tx_en,
    output logic             rx_block,
    output logic             frame_done,
    output logic             st_no_carrier,
    output logic             st_loss_carrier,
    output logic             st_excess_col
);
    localparam int ATT_W = $clog2(ATTEMPT_LIMIT + 1);

    seq_state_t       state;
    logic [LEN_W-1:0] nib_left;
    logic [ATT_W-1:0] attempts;
    logic             crs_seen;
    frame_status_t    status;
    logic             done_q;

    logic             tick, gap_ok, bo_expired;
    logic             half_dup, xmit_tick;
    logic             col_hit, carrier_lost, last_nib, give_up;
    logic             xmit_end, bo_load;
    logic [ATT_W-1:0] att_next;

    assign half_dup = !cfg_full_duplex;

    hdx_tick_gen #(.SLOW_DIV(SLOW_DIV)) u_tick (
        .clk(clk), .rst(rst), .speed_fast(speed_fast), .tick(tick)
    );

    always_comb begin
        xmit_tick    = tick && (state == ST_XMIT);
        col_hit      = half_dup && col;
        carrier_lost = half_dup && !cfg_crs_ignore && crs_seen && !crs;
        last_nib     = (nib_left == '0);
        att_next     = attempts + 1'b1;
        give_up      = cfg_no_retry || (att_next == ATT_W'(ATTEMPT_LIMIT));
        xmit_end     = xmit_tick && (col_hit || carrier_lost || last_nib);
        bo_load      = xmit_tick && col_hit && !give_up;
    end

    hdx_gap_timer u_gap (
        .clk(clk), .rst(rst), .tick(tick), .load(xmit_end),
        .code(cfg_gap), .full_dup(cfg_full_duplex), .elapsed(gap_ok)
    );

    hdx_backoff #(
        .ATT_W(ATT_W), .CAP(BACKOFF_CAP),
        .SLOT_TICKS(SLOT_TICKS), .SEED(LFSR_SEED)
    ) u_backoff (
        .clk(clk), .rst(rst), .tick(tick), .load(bo_load),
        .attempt(att_next), .expired(bo_expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            nib_left <= '0;
            attempts <= '0;
            crs_seen <= 1'b0;
            status   <= '0;
            done_q   <= 1'b0;
        end else begin
            status <= '0;
            done_q <= 1'b0;
            if (tick) begin
                unique case (state)
                    ST_IDLE: begin
                        if (gap_ok && frame_req && !(half_dup && crs)) begin
                            state    <= ST_XMIT;
                            nib_left <= frame_len - 1'b1;
                            crs_seen <= 1'b0;
                        end
                    end
                    ST_XMIT: begin
                        if (col_hit) begin
                            if (give_up) begin
                                state             <= ST_IDLE;
                                attempts          <= '0;
                                done_q            <= 1'b1;
                                status.excess_col <= 1'b1;
                            end else begin
                                state    <= ST_BACKOFF;
                                attempts <= att_next;
                            end
                        end else if (carrier_lost) begin
                            state               <= ST_IDLE;
                            attempts            <= '0;
                            done_q              <= 1'b1;
                            status.loss_carrier <= 1'b1;
                        end else if (last_nib) begin
                            state             <= ST_IDLE;
                            attempts          <= '0;
                            done_q            <= 1'b1;
                            status.no_carrier <= half_dup && !cfg_crs_ignore
                                                 && !crs_seen && !crs;
                        end else begin
                            nib_left <= nib_left - 1'b1;
                            crs_seen <= crs_seen | crs;
                        end
                    end
                    ST_BACKOFF: begin
                        if (bo_expired)
                            state <= ST_IDLE;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assign tx_en           = (state == ST_XMIT);
    assign rx_block        = tx_en && half_dup && cfg_rx_own_block;
    assign frame_done      = done_q;
    assign st_no_carrier   = status.no_carrier;
    assign st_loss_carrier = status.loss_carrier;
    assign st_excess_col   = status.excess_col;
endmodule

// File: rtl/hdx_tx_sequencer_chk.sv
module hdx_tx_sequencer_chk (
    input logic clk,
    input logic rst,
    input logic cfg_full_duplex,
    input logic cfg_rx_own_block,
    input logic crs,
    input logic tx_en,
    input logic rx_block,
    input logic frame_done,
    input logic st_no_carrier,
    input logic st_loss_carrier,
    input logic st_excess_col
);
    // R12
    status_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        (st_no_carrier || st_loss_carrier || st_excess_col) |-> frame_done);

    // R12
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

    // R12
    status_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({st_no_carrier, st_loss_carrier, st_excess_col}));

    // R12
    done_tx_low_chk: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> !tx_en);

    // R10
    rx_gate_chk: assert property (@(posedge clk) disable iff (rst)
        rx_block |-> (tx_en && !cfg_full_duplex && cfg_rx_own_block));

    // R2
    defer_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(tx_en) && !$past(cfg_full_duplex)) |-> !$past(crs));

    // R9
    fd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_done && $past(cfg_full_duplex))
        |-> !(st_no_carrier || st_loss_carrier || st_excess_col));
endmodule

bind hdx_tx_sequencer hdx_tx_sequencer_chk u_chk (
    .clk(clk), .rst(rst), .cfg_full_duplex(cfg_full_duplex),
    .cfg_rx_own_block(cfg_rx_own_block), .crs(crs), .tx_en(tx_en),
    .rx_block(rx_block), .frame_done(frame_done),
    .st_no_carrier(st_no_carrier), .st_loss_carrier(st_loss_carrier),
    .st_excess_col(st_excess_col)
);

// File: tb/hdx_tx_sequencer_test.sv
module hdx_tx_sequencer_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        speed_fast = 1'b1;
    logic [2:0]  cfg_gap = 3'd0;
    logic        cfg_full_duplex = 1'b1;
    logic        cfg_crs_ignore = 1'b0;
    logic        cfg_no_retry = 1'b0;
    logic        cfg_rx_own_block = 1'b0;
    logic        frame_req = 1'b0;
    logic [11:0] frame_len = 12'd1;
    logic        crs = 1'b0;
    logic        col = 1'b0;
    logic        tx_en, rx_block, frame_done;
    logic        st_no_carrier, st_loss_carrier, st_excess_col;

    always #2.5 clk = ~clk;

    hdx_tx_sequencer #(.SLOT_TICKS(2)) uut (
        .clk(clk), .rst(rst), .speed_fast(speed_fast), .cfg_gap(cfg_gap),
        .cfg_full_duplex(cfg_full_duplex), .cfg_crs_ignore(cfg_crs_ignore),
        .cfg_no_retry(cfg_no_retry), .cfg_rx_own_block(cfg_rx_own_block),
        .frame_req(frame_req), .frame_len(frame_len), .crs(crs), .col(col),
        .tx_en(tx_en), .rx_block(rx_block), .frame_done(frame_done),
        .st_no_carrier(st_no_carrier), .st_loss_carrier(st_loss_carrier),
        .st_excess_col(st_excess_col)
    );

    typedef struct {
        string tag;
        int    len_clk;
        bit    short_ok;
        bit    nc, loc, xc;
        int    attempts;
        int    gap;
        int    rx;
    } exp_t;

    exp_t sb[$];
    int   checks = 0;
    int   errors = 0;

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: %s actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Line model: crs echoes tx_en for a while, col follows tx_en on a budget
    bit crs_force = 0;
    bit crs_follow = 0;
    int crs_drop_at = 1000000;
    int col_budget = 0;
    int line_hi = 0;
    bit line_prev = 0;

    always @(negedge clk) begin
        if (tx_en) line_hi = line_prev ? line_hi + 1 : 1;
        if (line_prev && !tx_en && col_budget > 0) col_budget--;
        line_prev = tx_en;
        crs = crs_force | (crs_follow & tx_en & (line_hi <= crs_drop_at));
        col = tx_en & (col_budget > 0);
    end

    // Monitor
    int hi_cnt = 0, idle_cnt = 1000, rises = 0, gap_seen = -1;
    bit rx_any = 0, prev_tx = 0, prev_done = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (tx_en) begin
                if (!prev_tx) begin
                    if (rises == 0) gap_seen = idle_cnt;
                    rises++;
                    hi_cnt = 0;
                end
                hi_cnt++;
                if (rx_block) rx_any = 1;
            end else begin
                idle_cnt = prev_tx ? 1 : idle_cnt + 1;
            end
            if ((st_no_carrier | st_loss_carrier | st_excess_col) && !frame_done)
                chk("R12", "status without done", 1, 0);
            if (prev_done && frame_done)
                chk("R12", "done longer than one cycle", 1, 0);
            if (frame_done) begin
                if (sb.size() == 0) begin
                    chk("R12", "unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk("R12", "done coincides with tx_en fall", int'(prev_tx && !tx_en), 1);
                    if (e.short_ok)
                        chk(e.tag, "aborted early", int'(hi_cnt < e.len_clk), 1);
                    else
                        chk(e.tag, "tx_en length", hi_cnt, e.len_clk);
                    chk(e.tag, "no_carrier", int'(st_no_carrier), int'(e.nc));
                    chk(e.tag, "loss_carrier", int'(st_loss_carrier), int'(e.loc));
                    chk(e.tag, "excess_col", int'(st_excess_col), int'(e.xc));
                    if (e.attempts > 0) chk(e.tag, "attempts", rises, e.attempts);
                    if (e.gap >= 0) chk(e.tag, "gap ticks", gap_seen, e.gap);
                    if (e.rx >= 0) chk(e.tag, "rx_block seen", int'(rx_any), e.rx);
                end
                rises = 0;
                rx_any = 0;
            end
            prev_tx = tx_en;
            prev_done = frame_done;
        end
    end

    task automatic start_frame(int len, exp_t e);
        sb.push_back(e);
        frame_len = 12'(len);
        frame_req = 1'b1;
    endtask

    task automatic finish_frame();
        do @(negedge clk); while (!frame_done);
        frame_req = 1'b0;
    endtask

    function automatic exp_t mk(string tag, int len_clk, int gap);
        exp_t e;
        e.tag = tag; e.len_clk = len_clk; e.short_ok = 0;
        e.nc = 0; e.loc = 0; e.xc = 0;
        e.attempts = 0; e.gap = gap; e.rx = -1;
        return e;
    endfunction

    task automatic pair(string tag, int exp_gap);
        start_frame(6, mk(tag, 6, -1));
        finish_frame();
        start_frame(6, mk(tag, 6, exp_gap));
        finish_frame();
        repeat (30) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        exp_t e;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk("R12", "reset tx_en", int'(tx_en), 0);
        chk("R12", "reset done", int'(frame_done), 0);
        chk("R10", "reset rx_block", int'(rx_block), 0);
        repeat (30) @(negedge clk);

        // R1 gap in full duplex, code 0 and 7
        cfg_gap = 3'd0; pair("R1", 24);
        cfg_gap = 3'd7; pair("R1", 10);
        // R1 half-duplex clamp and unclamped code 2
        cfg_full_duplex = 1'b0; crs_follow = 1;
        cfg_gap = 3'd7; pair("R1", 16);
        cfg_gap = 3'd4; pair("R1", 16);
        cfg_gap = 3'd2; pair("R1", 20);

        // R2 deferral while crs high in half duplex
        cfg_gap = 3'd0;
        crs_force = 1;
        start_frame(5, mk("R2", 5, -1));
        begin
            int early = 0;
            repeat (40) begin
                @(negedge clk);
                if (tx_en) early++;
            end
            chk("R2", "tx_en while deferring", early, 0);
        end
        crs_force = 0;
        finish_frame();
        repeat (30) @(negedge clk);

        // R3 no carrier
        crs_follow = 0;
        e = mk("R3", 7, -1); e.nc = 1;
        start_frame(7, e); finish_frame();
        repeat (30) @(negedge clk);

        // R4 carrier lost mid-frame
        crs_follow = 1; crs_drop_at = 3;
        e = mk("R4", 20, -1); e.loc = 1; e.short_ok = 1;
        start_frame(20, e); finish_frame();
        repeat (30) @(negedge clk);

        // R5 carrier errors disabled, no carrier at all
        crs_follow = 0; crs_drop_at = 1000000;
        cfg_crs_ignore = 1;
        start_frame(9, mk("R5", 9, -1)); finish_frame();
        repeat (30) @(negedge clk);

        // R6 two collisions then success
        col_budget = 2;
        e = mk("R6", 8, -1); e.attempts = 3;
        start_frame(8, e); finish_frame();
        repeat (30) @(negedge clk);

        // R7 no retry
        cfg_no_retry = 1; col_budget = 1000;
        e = mk("R7", 8, -1); e.xc = 1; e.attempts = 1; e.short_ok = 1;
        start_frame(8, e); finish_frame();
        cfg_no_retry = 0;
        repeat (30) @(negedge clk);

        // R8 sixteen collisions
        col_budget = 1000;
        e = mk("R8", 8, -1); e.xc = 1; e.attempts = 16; e.short_ok = 1;
        start_frame(8, e); finish_frame();
        repeat (30) @(negedge clk);

        // R9 full duplex ignores col and crs
        cfg_full_duplex = 1; cfg_crs_ignore = 0; col_budget = 1000;
        e = mk("R9", 8, -1); e.attempts = 1;
        start_frame(8, e); finish_frame();
        col_budget = 0;
        repeat (30) @(negedge clk);

        // R10 receive gating in half and full duplex
        cfg_rx_own_block = 1;
        e = mk("R10", 6, -1); e.rx = 0;
        start_frame(6, e); finish_frame();
        repeat (30) @(negedge clk);
        cfg_full_duplex = 0; crs_follow = 1;
        e = mk("R10", 6, -1); e.rx = 1;
        start_frame(6, e); finish_frame();
        cfg_rx_own_block = 0;
        repeat (30) @(negedge clk);

        // R11 slow speed: ten clocks per nibble
        cfg_full_duplex = 1; crs_follow = 0;
        speed_fast = 0;
        start_frame(4, mk("R11", 40, -1)); finish_frame();
        repeat (300) @(negedge clk);
        speed_fast = 1;
        repeat (30) @(negedge clk);

        chk("R12", "scoreboard drained", sb.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule